// File: doc/BRIEF.md
# Valid/Ready Channel Protocol Monitor

This block sits passively beside one valid/ready channel and watches a source hand a payload to a destination. It never drives the channel. It raises sticky error flags when the source breaks the handshake rules. The rules are: withdrawing valid before the destination has taken the item, altering the payload while the item waits, and showing valid around reset. It also reports every completed transfer as a one-cycle pulse and as a running count. Ready is never checked. It may come before valid, after it, or in the same cycle, and it may sit high from reset onward.

The core is a three-state machine. GUARD is entered by reset and covers the first clock edge after reset is released. It always moves to IDLE (transition *release*). IDLE moves to STALL when valid is high and ready is low (transition *stall*), capturing the payload at that edge. STALL returns to IDLE either when ready accepts the item (transition *accept*) or when valid falls without acceptance (transition *drop*). A valid/ready overlap in IDLE is a transfer that keeps the machine in IDLE. Reset is synchronous and active low. Every output is registered, so an event seen at a clock edge shows on the outputs right after that edge.

Top module: `hs_monitor`

## Requirements
- R1: After reset, `err_flags`, `err_new`, `xfer_pulse` and `xfer_count` are all zero.
- R2: A transfer is counted at every clock edge after the first post-reset edge where `vld` and `rdy` are both high. This holds when valid leads ready by any number of cycles, when ready leads valid, and when both rise together. Right after that edge, `xfer_pulse` is 1 for one cycle and `xfer_count` has advanced by one.
- R3: Ready rising, falling or staying high while `vld` is low never sets an error and never counts a transfer.
- R4: `vld` falling while an item is stalled (valid was high and ready low at the previous edge) sets `err_flags[0]`.
- R5: A payload that differs at any stalled edge from the value captured when the stall began sets `err_flags[1]`. A payload that changes while `vld` is low, or between back-to-back accepted transfers, sets nothing.
- R6: `vld` high at the last clock edge of reset, or at the first edge after reset is released, sets `err_flags[2]`.
- R7: Each `err_flags` bit stays set until reset. The matching `err_new` bit is 1 only in the cycle the flag first becomes set, and it stays 0 when the same violation happens again.
- R8: `xfer_count` is `CNT_W` bits wide and wraps to zero after its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vld | input | 1 | Observed valid from the source |
| rdy | input | 1 | Observed ready from the destination |
| payload | input | PAY_W | Observed payload and control bits |
| err_flags | output | 3 | Sticky errors: bit 0 drop, bit 1 payload change, bit 2 reset violation |
| err_new | output | 3 | One-cycle pulse on the first detection of each error |
| xfer_pulse | output | 1 | One-cycle pulse per completed transfer |
| xfer_count | output | CNT_W | Wrapping count of transfers |

## Verification
The hardest condition to reach is a violation layered on top of an already stalled item. Examples are a payload change several cycles into a stall, or a second drop after the flag is already set. The stimulus builds these by sweeping stall length and ready lead time over small ranges, then injecting the fault at a chosen stalled cycle. The reset violation needs valid placed exactly on the last reset edge or the first edge after release, so the bench drives reset and valid together through a dedicated reset task.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;

    typedef enum logic [1:0] {
        ST_GUARD = 2'd0,
        ST_IDLE  = 2'd1,
        ST_STALL = 2'd2
    } hs_state_e;

    localparam int ERR_DROP = 0;
    localparam int ERR_CHG  = 1;
    localparam int ERR_RST  = 2;
    localparam int N_ERR    = 3;

endpackage

// File: rtl/hsmon_fsm.sv
module hsmon_fsm
    import hsmon_pkg::*;
#(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             rdy,
    input  logic [PAY_W-1:0] payload,
    output hs_state_e        state,
    output logic [N_ERR-1:0] det,
    output logic             hit
);

    hs_state_e        nxt;
    logic [PAY_W-1:0] held;
    logic             vld_in_rst;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_GUARD;
        else        state <= nxt;
    end

    // payload snapshot on stall entry; valid sampled on reset edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_in_rst <= vld;
            held       <= '0;
        end else if (state == ST_IDLE && vld && !rdy) begin
            held <= payload;
        end
    end

    // next state and event detection
    always_comb begin
        nxt = state;
        det = '0;
        hit = 1'b0;
        unique case (state)
            ST_GUARD: begin
                det[ERR_RST] = vld_in_rst | vld;
                nxt          = ST_IDLE;
            end
            ST_IDLE: begin
                if (vld) begin
                    if (rdy) hit = 1'b1;
                    else     nxt = ST_STALL;
                end
            end
            ST_STALL: begin
                if (!vld) begin
                    det[ERR_DROP] = 1'b1;
                    nxt           = ST_IDLE;
                end else begin
                    det[ERR_CHG] = (payload != held);
                    if (rdy) begin
                        hit = 1'b1;
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_GUARD;
        endcase
    end

endmodule

// File: rtl/hsmon_sticky.sv
module hsmon_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] det,
    output logic [N-1:0] flags,
    output logic [N-1:0] first
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
                first[g] <= 1'b0;
            end else begin
                flags[g] <= flags[g] | det[g];
                first[g] <= det[g] & ~flags[g];
            end
        end

        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            flags[g] |=> flags[g]);

        p_pulse_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
            first[g] |=> !first[g]);
    end

endmodule

// File: rtl/hsmon_counter.sv
module hsmon_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    output logic [CNT_W-1:0] count,
    output logic             pulse
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= hit;
            if (hit) count <= count + 1'b1;
        end
    end

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> count == CNT_W'($past(count) + 1'b1));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |-> $stable(count));

endmodule

// File: rtl/hs_monitor.sv
module hs_monitor
    import hsmon_pkg::*;
#(
    parameter int PAY_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             rdy,
    input  logic [PAY_W-1:0] payload,
    output logic [2:0]       err_flags,
    output logic [2:0]       err_new,
    output logic             xfer_pulse,
    output logic [CNT_W-1:0] xfer_count
);

    hs_state_e        fsm_state;
    logic [N_ERR-1:0] det;
    logic             hit;

    hsmon_fsm #(.PAY_W(PAY_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (vld),
        .rdy     (rdy),
        .payload (payload),
        .state   (fsm_state),
        .det     (det),
        .hit     (hit)
    );

    hsmon_sticky #(.N(N_ERR)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .det   (det),
        .flags (err_flags),
        .first (err_new)
    );

    hsmon_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .count (xfer_count),
        .pulse (xfer_pulse)
    );

    p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_STALL && !vld) |=> err_flags[ERR_DROP]);

    p_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_GUARD && vld && rdy) |=> xfer_pulse);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |=> (!err_new[ERR_DROP] && !err_new[ERR_CHG]));

    p_stall_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && vld && !rdy) |=> !err_new[ERR_CHG]);

endmodule

// File: tb/sim_hs_monitor.sv
`timescale 1ns/1ps
module sim_hs_monitor;

    localparam int PW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vld = 1'b0;
    logic          rdy = 1'b0;
    logic [PW-1:0] payload = '0;
    logic [2:0]    err_flags, err_new;
    logic          xfer_pulse;
    logic [CW-1:0] xfer_count;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    hs_monitor #(.PAY_W(PW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .vld(vld), .rdy(rdy), .payload(payload),
        .err_flags(err_flags), .err_new(err_new),
        .xfer_pulse(xfer_pulse), .xfer_count(xfer_count)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic r, input logic [PW-1:0] p);
        @(negedge clk);
        vld = v; rdy = r; payload = p;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic v_last);
        rst_n = 1'b0;
        step(0, 0, 0);
        step(v_last, 0, 0);
        rst_n = 1'b1;
        exp_cnt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(0);
        check("R1 flags", 32'(err_flags), 0);
        check("R1 new", 32'(err_new), 0);
        check("R1 pulse", 32'(xfer_pulse), 0);
        check("R1 count", 32'(xfer_count), 0);
        step(0, 0, 0);

        // R2 sweep of stall length and ready lead
        for (int s = 0; s < 5; s++) begin
            for (int e = 0; e < 2; e++) begin
                if (e == 1) begin
                    step(0, 1, 8'hA5);
                    check("R2 ready-first idle", 32'(xfer_pulse), 0);
                end
                for (int k = 0; k < s; k++) begin
                    step(1, 0, 8'(s * 16 + e));
                    check("R2 stalled", 32'(xfer_pulse), 0);
                end
                step(1, 1, 8'(s * 16 + e));
                exp_cnt++;
                check("R2 accept pulse", 32'(xfer_pulse), 1);
                check("R2 accept count", 32'(xfer_count), 32'(exp_cnt % 16));
                step(0, e[0], 0);
                check("R2 after accept", 32'(xfer_pulse), 0);
            end
        end
        check("R5 no false flags after sweep", 32'(err_flags), 0);

        // R5/R8 back-to-back transfers with changing payload, crossing the wrap
        for (int i = 0; i < 20; i++) begin
            step(1, 1, 8'(i * 3));
            exp_cnt++;
            check("R2 back-to-back pulse", 32'(xfer_pulse), 1);
            check("R8 wrap count", 32'(xfer_count), 32'(exp_cnt % 16));
        end
        step(0, 0, 0);
        check("R5 back-to-back no flag", 32'(err_flags), 0);

        // R3 ready toggling alone, payload wandering with valid low
        for (int i = 0; i < 6; i++) begin
            step(0, 1'(i % 2), 8'(i + 40));
            check("R3 no xfer", 32'(xfer_pulse), 0);
            check("R3 no flag", 32'(err_flags), 0);
        end
        check("R3 count held", 32'(xfer_count), 32'(exp_cnt % 16));

        // R4 drop, R7 stickiness
        do_reset(0);
        step(0, 0, 0);
        step(1, 0, 7);
        check("R4 stalled clean", 32'(err_flags), 0);
        step(0, 0, 7);
        check("R4 drop flag", 32'(err_flags), 1);
        check("R7 drop first pulse", 32'(err_new), 1);
        step(0, 0, 0);
        check("R7 pulse ends", 32'(err_new), 0);
        step(1, 0, 1);
        step(0, 0, 1);
        check("R7 repeat no pulse", 32'(err_new), 0);
        check("R7 flag sticks", 32'(err_flags), 1);
        check("R4 drop not counted", 32'(xfer_count), 0);

        // R5 payload change deep in a stall
        do_reset(0);
        check("R7 reset clears", 32'(err_flags), 0);
        step(0, 0, 0);
        step(1, 0, 5);
        step(1, 0, 5);
        check("R5 stable stall", 32'(err_flags), 0);
        step(1, 0, 6);
        check("R5 change flag", 32'(err_flags), 2);
        check("R5 change pulse", 32'(err_new), 2);
        step(1, 1, 6);
        check("R7 change repeat no pulse", 32'(err_new), 0);
        check("R2 accept after change", 32'(xfer_count), 1);
        check("R7 change sticky", 32'(err_flags), 2);

        // R6 valid on the last reset edge
        do_reset(1);
        step(0, 0, 0);
        check("R6 valid in reset", 32'(err_flags), 4);
        check("R6 pulse", 32'(err_new), 4);
        // R6 valid on first edge after release
        do_reset(0);
        step(1, 0, 0);
        check("R6 valid after release", 32'(err_flags), 4);
        step(0, 0, 0);
        // R6 clean release
        do_reset(0);
        step(0, 1, 0);
        check("R6 clean release", 32'(err_flags), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule